// File: doc/BRIEF.md
# Counter Update Collision Merger

This block sits between a source of counter-update requests and four parallel read-modify-write lanes. Every clock cycle each of the four lanes may carry one request. A request holds a counter address and a 72-bit increment word made of a packet count and a byte count. Downstream logic reads each counter, adds the increment and writes the result back. Two requests for the same counter that are in flight together would each read the old value, and one update would be lost. This block removes those collisions. It adds the colliding increments together into a single surviving request and cancels the others, so no request is ever stalled or reordered.

The first stage compares the four addresses presented in one cycle. The lowest-numbered lane with a given address keeps the combined increment, and every higher-numbered lane with that address is cancelled. The second stage works on each lane separately. It holds the last `WIN` merged requests in a short delay line. A new request whose address matches an entry still inside the line is folded into that entry, and the new slot leaves empty. A cancelled slot reaches the output with its valid low. The position of each lane and the order of its surviving requests are preserved.

Top module: `stat_coalesce`

## Requirements
- R1: While reset is held, and after it is released with no input, every output valid bit is low.
- R2: A request that meets no collision appears on the same lane, with the same address and increment, exactly `WIN`+1 cycles after it is presented (5 cycles by default). It is not visible one cycle earlier.
- R3: When several valid lanes carry the same address in one cycle, the lowest-numbered of them outputs the sum of all their increments. The higher-numbered matching lanes are output with valid low.
- R4: Valid lanes with pairwise distinct addresses in one cycle pass through independently, each keeping its own address and increment.
- R5: On one lane, a later request whose address matches a surviving earlier request presented 1 to `WIN`-1 cycles before it is cancelled (its slot leaves invalid). Its increment is added into the earlier request's output.
- R6: On one lane, requests to the same address that are `WIN` or more cycles apart are output separately, each unchanged.
- R7: The packet count is bits [31:0] and the byte count is bits [71:32] of the increment word. Each field is summed on its own and saturates at its all-ones value without carrying into the other field.
- R8: A slot whose valid is low is ignored. Its address and increment take part in no merge, and its output slot is invalid.
- R9: The two stages compose. A request first combined across lanes is still merged with a later same-lane request to the same address inside the window, even when requests to other addresses lie between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | NUM_CH | Request valid, one bit per lane |
| in_addr_i | input | NUM_CH*ADDR_W | Counter addresses; lane n in bits [n*ADDR_W +: ADDR_W] |
| in_inc_i | input | NUM_CH*72 | Increment words; lane n in bits [n*72 +: 72] |
| out_valid_o | output | NUM_CH | Merged request valid per lane |
| out_addr_o | output | NUM_CH*ADDR_W | Merged request addresses, same packing as the input |
| out_inc_o | output | NUM_CH*72 | Merged increment words, same packing as the input |

## Verification
The bench drives several input patterns:
- A single request on one lane and four distinct addresses, which separate plain pass-through and exact latency from any merging.
- Same-cycle collisions among three lanes and among two separate pairs, which expose a wrong priority order or a wrong grouping of lanes.
- Same-lane repeats three and four cycles apart, which pin down the edge of the window.
- Increments near the top of each field, together with invalid slots that carry a matching address, which show whether the saturation and the valid qualification are done correctly.
- A lane-merged request followed two cycles later by a repeat, with another address in between, which checks that the stages compose.

// File: rtl/stat_coalesce_pkg.sv
package stat_coalesce_pkg;
  localparam int PKT_W = 32;
  localparam int BYTE_W = 40;
  localparam int INC_W = PKT_W + BYTE_W;

  // per-field saturating add; fields never carry into each other
  function automatic logic [INC_W-1:0] inc_add(input logic [INC_W-1:0] a,
                                               input logic [INC_W-1:0] b);
    logic [PKT_W:0]   p;
    logic [BYTE_W:0]  y;
    logic [INC_W-1:0] r;
    p = {1'b0, a[PKT_W-1:0]} + {1'b0, b[PKT_W-1:0]};
    y = {1'b0, a[INC_W-1:PKT_W]} + {1'b0, b[INC_W-1:PKT_W]};
    r[PKT_W-1:0]     = p[PKT_W]  ? {PKT_W{1'b1}}  : p[PKT_W-1:0];
    r[INC_W-1:PKT_W] = y[BYTE_W] ? {BYTE_W{1'b1}} : y[BYTE_W-1:0];
    return r;
  endfunction
endpackage

// File: rtl/stat_xch_merge.sv
module stat_xch_merge
  import stat_coalesce_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 22
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_CH-1:0]                v_i,
  input  logic [NUM_CH-1:0][ADDR_W-1:0]    a_i,
  input  logic [NUM_CH-1:0][INC_W-1:0]     inc_i,
  output logic [NUM_CH-1:0]                v_o,
  output logic [NUM_CH-1:0][ADDR_W-1:0]    a_o,
  output logic [NUM_CH-1:0][INC_W-1:0]     inc_o
);
  logic [NUM_CH-1:0]            keep;
  logic [NUM_CH-1:0][INC_W-1:0] sum;

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      keep[i] = v_i[i];
      sum[i]  = inc_i[i];
      for (int j = 0; j < NUM_CH; j++) begin
        if (v_i[j] && a_i[j] == a_i[i]) begin
          if (j < i) keep[i] = 1'b0;                      // higher priority lane owns it
          else if (j > i) sum[i] = inc_add(sum[i], inc_i[j]);
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_o   <= '0;
      a_o   <= '0;
      inc_o <= '0;
    end else begin
      v_o   <= keep;
      a_o   <= a_i;
      inc_o <= sum;
    end
  end

  AST_CH0_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_i[0] |=> v_o[0]); // R3

  AST_LOW_CANCEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_i[0] && v_i[1] && a_i[0] == a_i[1]) |=> !v_o[1]); // R3

  for (genvar i = 0; i < NUM_CH; i++) begin : g_pi
    for (genvar j = i + 1; j < NUM_CH; j++) begin : g_pj
      AST_S1_UNIQUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(v_o[i] && v_o[j] && a_o[i] == a_o[j])); // R3
    end
  end
endmodule

// File: rtl/stat_win_merge.sv
module stat_win_merge
  import stat_coalesce_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int WIN    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              v_i,
  input  logic [ADDR_W-1:0] a_i,
  input  logic [INC_W-1:0]  inc_i,
  output logic              v_o,
  output logic [ADDR_W-1:0] a_o,
  output logic [INC_W-1:0]  inc_o
);
  logic [WIN-1:0]             d_v;
  logic [WIN-1:0][ADDR_W-1:0] d_a;
  logic [WIN-1:0][INC_W-1:0]  d_inc;
  logic [WIN-2:0]             hit;

  // the tail entry leaves at this edge, so it takes no merge
  always_comb begin
    for (int k = 0; k < WIN - 1; k++) hit[k] = v_i && d_v[k] && d_a[k] == a_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_v   <= '0;
      d_a   <= '0;
      d_inc <= '0;
    end else begin
      d_v[0]   <= v_i && !(|hit);
      d_a[0]   <= a_i;
      d_inc[0] <= inc_i;
      for (int k = 1; k < WIN; k++) begin
        d_v[k]   <= d_v[k-1];
        d_a[k]   <= d_a[k-1];
        d_inc[k] <= hit[k-1] ? inc_add(d_inc[k-1], inc_i) : d_inc[k-1];
      end
    end
  end

  assign v_o   = d_v[WIN-1];
  assign a_o   = d_a[WIN-1];
  assign inc_o = d_inc[WIN-1];

  for (genvar k = 0; k < WIN; k++) begin : g_uk
    for (genvar m = k + 1; m < WIN; m++) begin : g_um
      AST_WIN_UNIQUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(d_v[k] && d_v[m] && d_a[k] == d_a[m])); // R5
    end
  end
endmodule

// File: rtl/stat_coalesce.sv
module stat_coalesce
  import stat_coalesce_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 22,
  parameter int WIN    = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_CH-1:0]          in_valid_i,
  input  logic [NUM_CH*ADDR_W-1:0]   in_addr_i,
  input  logic [NUM_CH*INC_W-1:0]    in_inc_i,
  output logic [NUM_CH-1:0]          out_valid_o,
  output logic [NUM_CH*ADDR_W-1:0]   out_addr_o,
  output logic [NUM_CH*INC_W-1:0]    out_inc_o
);
  logic [NUM_CH-1:0][ADDR_W-1:0] a_in, a_s1, a_out;
  logic [NUM_CH-1:0][INC_W-1:0]  i_in, i_s1, i_out;
  logic [NUM_CH-1:0]             v_s1;

  assign a_in = in_addr_i;
  assign i_in = in_inc_i;

  stat_xch_merge #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_xch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .v_i   (in_valid_i),
    .a_i   (a_in),
    .inc_i (i_in),
    .v_o   (v_s1),
    .a_o   (a_s1),
    .inc_o (i_s1)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
    stat_win_merge #(.ADDR_W(ADDR_W), .WIN(WIN)) u_win (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .v_i   (v_s1[g]),
      .a_i   (a_s1[g]),
      .inc_i (i_s1[g]),
      .v_o   (out_valid_o[g]),
      .a_o   (a_out[g]),
      .inc_o (i_out[g])
    );
  end

  assign out_addr_o = a_out;
  assign out_inc_o  = i_out;

  AST_RST_IDLE: assert property (@(posedge clk_i) $rose(rst_ni) |-> out_valid_o == '0); // R1
endmodule

// File: tb/stat_coalesce_tb.sv
module stat_coalesce_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int AW = 22;
  localparam int IW = 72;
  localparam int WIN = 4;
  localparam int LAT = WIN + 1;
  localparam int NS = 12;
  localparam int NC = NS + LAT + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0]          in_v;
  logic [NCH-1:0][AW-1:0]  in_a;
  logic [NCH-1:0][IW-1:0]  in_i;
  logic [NCH-1:0]          out_v;
  logic [NCH-1:0][AW-1:0]  out_a;
  logic [NCH-1:0][IW-1:0]  out_i;

  int total = 0;
  int bad = 0;

  logic [NCH-1:0]         sv [NS];
  logic [NCH-1:0][AW-1:0] sa [NS];
  logic [NCH-1:0][IW-1:0] si [NS];
  logic [NCH-1:0]         cv [NC];
  logic [NCH-1:0][AW-1:0] ca [NC];
  logic [NCH-1:0][IW-1:0] ci [NC];

  always #(CLK_PERIOD/2) clk = ~clk;

  stat_coalesce #(.NUM_CH(NCH), .ADDR_W(AW), .WIN(WIN)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_v), .in_addr_i(in_a), .in_inc_i(in_i),
    .out_valid_o(out_v), .out_addr_o(out_a), .out_inc_o(out_i)
  );

  function automatic logic [IW-1:0] mk(input logic [39:0] bytes, input logic [31:0] pkts);
    return {bytes, pkts};
  endfunction

  task automatic chk(input string req, input logic [IW-1:0] act, input logic [IW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic exp_ch(input string req, input int k, input int ch, input logic v,
                        input logic [AW-1:0] a, input logic [IW-1:0] inc);
    chk(req, IW'(cv[k][ch]), IW'(v));
    if (v) begin
      chk(req, IW'(ca[k][ch]), IW'(a));
      chk(req, ci[k][ch], inc);
    end
  endtask

  task automatic clr();
    for (int k = 0; k < NS; k++) begin
      sv[k] = '0; sa[k] = '0; si[k] = '0;
    end
  endtask

  task automatic put(input int k, input int ch, input logic v, input logic [AW-1:0] a,
                     input logic [IW-1:0] inc);
    sv[k][ch] = v; sa[k][ch] = a; si[k][ch] = inc;
  endtask

  task automatic run();
    for (int k = 0; k < NC; k++) begin
      @(negedge clk);
      cv[k] = out_v; ca[k] = out_a; ci[k] = out_i;
      if (k < NS) begin
        in_v = sv[k]; in_a = sa[k]; in_i = si[k];
      end else begin
        in_v = '0; in_a = '0; in_i = '0;
      end
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 during reset", IW'(out_v), '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 after reset", IW'(out_v), '0);
  endtask

  task automatic t_lone();
    clr();
    put(0, 2, 1'b1, 22'd5, mk(40'd77, 32'd3));
    run();
    chk("R2 not early", IW'(cv[LAT-1]), '0);
    exp_ch("R2 lone", LAT, 2, 1'b1, 22'd5, mk(40'd77, 32'd3));
    chk("R2 others idle", IW'(cv[LAT] & 4'b1011), '0);
  endtask

  task automatic t_distinct();
    clr();
    for (int c = 0; c < NCH; c++) put(0, c, 1'b1, AW'(100 + c), mk(40'(c + 1), 32'(c + 1)));
    run();
    for (int c = 0; c < NCH; c++) exp_ch("R4 distinct", LAT, c, 1'b1, AW'(100 + c), mk(40'(c + 1), 32'(c + 1)));
  endtask

  task automatic t_cross();
    clr();
    put(0, 0, 1'b1, 22'd7, mk(40'd100, 32'd1));
    put(0, 1, 1'b1, 22'd9, mk(40'd10, 32'd1));
    put(0, 2, 1'b1, 22'd9, mk(40'd20, 32'd2));
    put(0, 3, 1'b1, 22'd9, mk(40'd30, 32'd3));
    put(3, 0, 1'b1, 22'd40, mk(40'd5, 32'd1));
    put(3, 3, 1'b1, 22'd40, mk(40'd7, 32'd2));
    put(3, 1, 1'b1, 22'd41, mk(40'd1, 32'd1));
    put(3, 2, 1'b1, 22'd41, mk(40'd2, 32'd2));
    run();
    exp_ch("R3 three-way", LAT, 1, 1'b1, 22'd9, mk(40'd60, 32'd6));
    exp_ch("R3 own lane", LAT, 0, 1'b1, 22'd7, mk(40'd100, 32'd1));
    chk("R3 cancelled", IW'(cv[LAT][3:2]), '0);
    exp_ch("R3 pair0-3", LAT + 3, 0, 1'b1, 22'd40, mk(40'd12, 32'd3));
    exp_ch("R3 pair1-2", LAT + 3, 1, 1'b1, 22'd41, mk(40'd3, 32'd3));
    chk("R3 pair cancelled", IW'(cv[LAT + 3][3:2]), '0);
  endtask

  task automatic t_window();
    clr();
    put(0, 1, 1'b1, 22'd20, mk(40'd50, 32'd5));
    put(3, 1, 1'b1, 22'd20, mk(40'd8, 32'd2));
    put(0, 3, 1'b1, 22'd30, mk(40'd1, 32'd1));
    put(4, 3, 1'b1, 22'd30, mk(40'd2, 32'd2));
    run();
    exp_ch("R5 merged", LAT, 1, 1'b1, 22'd20, mk(40'd58, 32'd7));
    chk("R5 later cancelled", IW'(cv[LAT + 3][1]), '0);
    exp_ch("R6 first", LAT, 3, 1'b1, 22'd30, mk(40'd1, 32'd1));
    exp_ch("R6 second", LAT + 4, 3, 1'b1, 22'd30, mk(40'd2, 32'd2));
  endtask

  task automatic t_sat();
    clr();
    put(0, 0, 1'b1, 22'd50, mk(40'd3, 32'hFFFF_FFF0));
    put(0, 1, 1'b1, 22'd50, mk(40'd4, 32'h20));
    put(0, 2, 1'b1, 22'd60, mk(40'hFF_FFFF_FF00, 32'd1));
    put(1, 2, 1'b1, 22'd60, mk(40'h200, 32'd2));
    run();
    exp_ch("R7 pkt sat", LAT, 0, 1'b1, 22'd50, mk(40'd7, 32'hFFFF_FFFF));
    exp_ch("R7 byte sat", LAT, 2, 1'b1, 22'd60, mk(40'hFF_FFFF_FFFF, 32'd3));
  endtask

  task automatic t_invalid();
    clr();
    put(0, 0, 1'b1, 22'd3, mk(40'd9, 32'd9));
    put(0, 1, 1'b0, 22'd3, mk(40'hFF, 32'hFF));
    put(1, 0, 1'b0, 22'd3, mk(40'hAA, 32'hAA));
    put(1, 1, 1'b0, 22'd3, mk(40'hBB, 32'hBB));
    run();
    exp_ch("R8 untouched", LAT, 0, 1'b1, 22'd3, mk(40'd9, 32'd9));
    chk("R8 invalid out", IW'(cv[LAT][1]), '0);
    chk("R8 invalid next", IW'(cv[LAT + 1][1:0]), '0);
  endtask

  task automatic t_combo();
    clr();
    put(0, 0, 1'b1, 22'd11, mk(40'd1, 32'd1));
    put(0, 1, 1'b1, 22'd11, mk(40'd2, 32'd2));
    put(1, 0, 1'b1, 22'd12, mk(40'd5, 32'd5));
    put(2, 0, 1'b1, 22'd11, mk(40'd4, 32'd4));
    run();
    exp_ch("R9 combined", LAT, 0, 1'b1, 22'd11, mk(40'd7, 32'd7));
    chk("R9 lane1 cancelled", IW'(cv[LAT][1]), '0);
    exp_ch("R9 between", LAT + 1, 0, 1'b1, 22'd12, mk(40'd5, 32'd5));
    chk("R9 repeat cancelled", IW'(cv[LAT + 2][0]), '0);
  endtask

  initial begin
    in_v = '0; in_a = '0; in_i = '0;
    t_reset();
    t_lone();
    t_distinct();
    t_cross();
    t_window();
    t_sat();
    t_invalid();
    t_combo();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule